// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned words of parameterised width plus a carry-in, and presents the sum and the carry-out with no clock and no state. It does not pass a carry from bit to bit along a chain. Each bit position first produces a generate/propagate pair. A prefix network then combines those pairs in a logarithmic number of levels, so every carry is known after about log2(N) combining cells instead of N. A final XOR level forms each sum bit from its propagate term and its incoming carry.

The carry-in is handled as an extra bit position below bit zero. Its generate term is the carry-in and its propagate term is zero. As a result, the prefix at every position is the carry into the next bit, and the carry-in needs no special path. An optional subtract control, kept in the design by a parameter, inverts the second operand and forces the carry-in high. The same network then produces the two's-complement difference. A second tree variant, a linear prefix scan, can be chosen by parameter when area matters more than depth. It gives the same function.

Top module: `ppa_adder`

## Requirements
- R1: With subtraction inactive, {cout, sum} equals opa + opb + cin as an unsigned (WIDTH+1)-bit value.
- R2: With SUB_EN=1 and sub=1, sum equals (opa - opb) mod 2^WIDTH. cout is 1 exactly when opa >= opb, which means no borrow. The cin input has no effect while sub=1.
- R3: For every bit i, sum[i] XOR opa[i] XOR opb[i] (with opb inverted when subtracting) equals the carry into bit i. That carry follows c[i+1] = (x[i] AND y[i]) OR ((x[i] XOR y[i]) AND c[i]), with c[0] the effective carry-in. cout is c[WIDTH].
- R4: All-ones opa plus zero opb with cin=1 gives sum 0 and cout 1, a carry that crosses every position.
- R5: All-zero operands give sum 0 and cout 0 with cin=0. With cin=1 they give sum 1 and cout 0.
- R6: Alternating patterns (opa = 0101..., opb = 1010...) give all-ones with cout 0 when cin=0. They give zero with cout 1 when cin=1.
- R7: With SUB_EN=0 the sub input has no effect on sum or cout.
- R8: The linear-scan tree variant (TREE_KIND=1) produces the same sum and cout as the logarithmic variant (TREE_KIND=0) for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input     | WIDTH | First operand (minuend when subtracting) |
| opb  | input     | WIDTH | Second operand (subtrahend when subtracting) |
| cin  | input     | 1     | Carry into bit 0; ignored while subtracting |
| sub  | input     | 1     | 1 selects opa - opb when SUB_EN=1 |
| sum  | output    | WIDTH | Sum or difference |
| cout | output    | 1     | Carry out of the top bit (1 = no borrow when subtracting) |

## Verification
The block is combinational, so a wrong combining cell shows at the ports in the same evaluation as the input that exercises it. It shows as a flipped sum bit at the position whose prefix is wrong, and often at positions above it as well. A cell that swaps its higher and lower operands, or that drops the propagate AND, is visible only for inputs whose carry has to cross the span of that cell. For that reason the bench recovers every internal carry from sum XOR operands and compares it with a bit-serial recurrence. It also runs long propagate runs and an exhaustive narrow instance, not only random sums.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

   // Generate/propagate pair for a single bit or a group of bits
   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Tree variant selectors
   localparam int TREE_LOG    = 0;
   localparam int TREE_LINEAR = 1;

   // Associative, non-commutative combine: 'hi' covers the more significant span
   function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

endpackage

// File: rtl/ppa_gp_stage.sv
module ppa_gp_stage
   import ppa_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int SUB_EN = 1,
   localparam int NODES = WIDTH + 1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   input  logic             sub,
   output gp_t  [NODES-1:0] node_o,
   output logic [WIDTH-1:0] prop_o
);

   logic [WIDTH-1:0] y_eff;
   logic             c_eff;

   generate
      if (SUB_EN != 0) begin : g_sub
         assign y_eff = sub ? ~opb : opb;
         assign c_eff = sub | cin & ~sub;
      end else begin : g_nosub
         assign y_eff = opb;
         assign c_eff = cin;
      end
   endgenerate

   // Node 0 stands for the carry-in as a generate-only position below bit 0
   assign node_o[0] = '{g: c_eff, p: 1'b0};

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign node_o[i+1] = '{g: opa[i] & y_eff[i], p: opa[i] ^ y_eff[i]};
         assign prop_o[i]   = opa[i] ^ y_eff[i];
      end
   endgenerate

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
   import ppa_pkg::*;
#(
   parameter int NODES     = 33,
   parameter int TREE_KIND = TREE_LOG,
   localparam int LEVELS   = (NODES > 1) ? $clog2(NODES) : 1
) (
   input  gp_t  [NODES-1:0] node_i,
   output logic [NODES-1:0] carry_o
);

   generate
      if (TREE_KIND == TREE_LOG) begin : g_log
         // Span doubles at each level; every node combines with the one 2^k below
         gp_t [NODES-1:0] stage [LEVELS+1];

         always_comb begin
            stage[0] = node_i;
            for (int k = 0; k < LEVELS; k++) begin
               for (int j = 0; j < NODES; j++) begin
                  if (j >= (1 << k)) begin
                     stage[k+1][j] = gp_merge(stage[k][j], stage[k][j - (1 << k)]);
                  end else begin
                     stage[k+1][j] = stage[k][j];
                  end
               end
            end
         end

         for (genvar j = 0; j < NODES; j++) begin : g_out
            assign carry_o[j] = stage[LEVELS][j].g;
         end
      end else begin : g_linear
         // One combine per node, scanned from the bottom
         gp_t [NODES-1:0] scan;

         always_comb begin
            scan[0] = node_i[0];
            for (int j = 1; j < NODES; j++) begin
               scan[j] = gp_merge(node_i[j], scan[j-1]);
            end
         end

         for (genvar j = 0; j < NODES; j++) begin : g_out
            assign carry_o[j] = scan[j].g;
         end
      end
   endgenerate

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
   parameter int WIDTH  = 32,
   localparam int NODES = WIDTH + 1
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [NODES-1:0] carry_i,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i] = prop_i[i] ^ carry_i[i];
      end
   endgenerate

   assign cout = carry_i[WIDTH];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
   import ppa_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int SUB_EN    = 1,
   parameter int TREE_KIND = TREE_LOG
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int NODES = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ppa_adder: WIDTH must be at least 1");
      end
      if (TREE_KIND != TREE_LOG && TREE_KIND != TREE_LINEAR) begin : g_bad_tree
         $error("ppa_adder: TREE_KIND selects an unknown tree variant");
      end
      if (SUB_EN != 0 && SUB_EN != 1) begin : g_bad_sub
         $error("ppa_adder: SUB_EN must be 0 or 1");
      end
   endgenerate

   gp_t  [NODES-1:0] gp_nodes;
   logic [WIDTH-1:0] prop_bits;
   logic [NODES-1:0] carries;

   ppa_gp_stage #(
      .WIDTH  (WIDTH),
      .SUB_EN (SUB_EN)
   ) u_gp (
      .opa    (opa),
      .opb    (opb),
      .cin    (cin),
      .sub    (sub),
      .node_o (gp_nodes),
      .prop_o (prop_bits)
   );

   ppa_prefix_tree #(
      .NODES     (NODES),
      .TREE_KIND (TREE_KIND)
   ) u_tree (
      .node_i  (gp_nodes),
      .carry_o (carries)
   );

   ppa_sum_stage #(
      .WIDTH (WIDTH)
   ) u_sum (
      .prop_i  (prop_bits),
      .carry_i (carries),
      .sum     (sum),
      .cout    (cout)
   );

endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk
   import ppa_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int SUB_EN = 1,
   localparam int NODES = WIDTH + 1
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             cin,
   input logic             sub,
   input logic [WIDTH-1:0] sum,
   input logic             cout,
   input gp_t  [NODES-1:0] nodes,
   input logic [NODES-1:0] carry
);

   logic              sub_act;
   logic [WIDTH:0]    add_ref;
   logic [WIDTH:0]    dif_ref;
   logic              known;

   assign sub_act = (SUB_EN != 0) && sub;
   assign add_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
   assign dif_ref = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};
   assign known   = !$isunknown({opa, opb, cin, sub});

   always_comb begin
      if (known) begin
         // R1: arithmetic result when adding
         if (!sub_act) begin
            a_r1_sum_matches: assert ({cout, sum} == add_ref)
               else $error("R1 sum mismatch");
         end
         // R2: difference and no-borrow flag
         if (sub_act) begin
            a_r2_difference: assert (sum == dif_ref[WIDTH-1:0] && cout == (opa >= opb))
               else $error("R2 difference mismatch");
         end
         // R3: tree prefixes obey the bit-serial recurrence
         a_r3_carry_base: assert (carry[0] == nodes[0].g)
            else $error("R3 carry-in node mismatch");
         for (int i = 0; i < WIDTH; i++) begin
            a_r3_recurrence: assert (carry[i+1] == (nodes[i+1].g | (nodes[i+1].p & carry[i])))
               else $error("R3 carry recurrence broken at bit %0d", i);
         end
         // R4: a fully propagating word passes the carry-in straight to cout
         if (&(opa ^ (sub_act ? ~opb : opb))) begin
            a_r4_full_propagate: assert (cout == carry[0] && sum == '0 ^ {WIDTH{~carry[0]}})
               else $error("R4 full propagate mismatch");
         end
      end
   end

endmodule

bind ppa_adder ppa_adder_chk #(
   .WIDTH  (WIDTH),
   .SUB_EN (SUB_EN)
) u_chk (
   .opa   (opa),
   .opb   (opb),
   .cin   (cin),
   .sub   (sub),
   .sum   (sum),
   .cout  (cout),
   .nodes (gp_nodes),
   .carry (carries)
);

// File: tb/tb_ppa_adder.sv
module tb_ppa_adder;

   localparam int W  = 32;
   localparam int WL = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [W-1:0]  a, b;
   logic          ci, sb;
   logic [W-1:0]  s;
   logic          co;

   logic [WL-1:0] la, lb;
   logic          lci, lsb;
   logic [WL-1:0] ls, ls_ref;
   logic          lco, lco_ref;

   ppa_adder #(.WIDTH(W), .SUB_EN(1), .TREE_KIND(0)) dut (
      .opa(a), .opb(b), .cin(ci), .sub(sb), .sum(s), .cout(co)
   );

   // Narrow instances: linear tree without subtract, and log tree without subtract
   ppa_adder #(.WIDTH(WL), .SUB_EN(0), .TREE_KIND(1)) dut_lin (
      .opa(la), .opb(lb), .cin(lci), .sub(lsb), .sum(ls), .cout(lco)
   );
   ppa_adder #(.WIDTH(WL), .SUB_EN(0), .TREE_KIND(0)) dut_ref (
      .opa(la), .opb(lb), .cin(lci), .sub(1'b0), .sum(ls_ref), .cout(lco_ref)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                        input logic xc, input logic xs);
      @(negedge clk);
      a = xa; b = xb; ci = xc; sb = xs;
      #3;
   endtask

   function automatic logic [W:0] ref_add(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                          input logic xc);
      return {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc};
   endfunction

   // Bit-serial carries into each position, independent of any tree
   function automatic logic [W-1:0] ref_carries(input logic [W-1:0] x, input logic [W-1:0] y,
                                                input logic c0);
      logic [W-1:0] v;
      logic c;
      c = c0;
      for (int i = 0; i < W; i++) begin
         v[i] = c;
         c = (x[i] & y[i]) | ((x[i] ^ y[i]) & c);
      end
      return v;
   endfunction

   task automatic t_zero();
      drive('0, '0, 1'b0, 1'b0);
      chk("R5 zero sum", {31'b0, co, s}, 64'd0);
      drive('0, '0, 1'b1, 1'b0);
      chk("R5 zero plus carry-in", {31'b0, co, s}, 64'd1);
   endtask

   task automatic t_all_ones();
      drive('1, '0, 1'b1, 1'b0);
      chk("R4 all ones plus one sum", {32'b0, s}, 64'd0);
      chk("R4 all ones plus one cout", {63'b0, co}, 64'd1);
      drive('1, 32'd1, 1'b0, 1'b0);
      chk("R4 all ones plus opb=1", {31'b0, co, s}, {31'b0, 1'b1, 32'd0});
      drive('1, '1, 1'b1, 1'b0);
      chk("R1 all ones plus all ones plus one", {31'b0, co, s}, {31'b0, ref_add('1, '1, 1'b1)});
   endtask

   task automatic t_alternating();
      drive({16{2'b01}}, {16{2'b10}}, 1'b0, 1'b0);
      chk("R6 alternating no carry-in", {31'b0, co, s}, {31'b0, 1'b0, 32'hFFFF_FFFF});
      drive({16{2'b01}}, {16{2'b10}}, 1'b1, 1'b0);
      chk("R6 alternating with carry-in", {31'b0, co, s}, {31'b0, 1'b1, 32'h0});
      drive({16{2'b01}}, {16{2'b01}}, 1'b1, 1'b0);
      chk("R1 alternating doubled", {31'b0, co, s},
          {31'b0, ref_add({16{2'b01}}, {16{2'b01}}, 1'b1)});
   endtask

   task automatic t_random_add();
      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] xa, xb;
         logic xc;
         xa = $urandom; xb = $urandom; xc = 1'($urandom);
         if (n % 4 == 1) xb = ~xa;
         drive(xa, xb, xc, 1'b0);
         chk("R1 random add", {31'b0, co, s}, {31'b0, ref_add(xa, xb, xc)});
         chk("R3 carries from sum", {32'b0, s ^ xa ^ xb}, {32'b0, ref_carries(xa, xb, xc)});
      end
   endtask

   task automatic t_subtract();
      drive(32'd77, 32'd77, 1'b0, 1'b1);
      chk("R2 equal operands", {31'b0, co, s}, {31'b0, 1'b1, 32'd0});
      drive(32'd5, 32'd9, 1'b0, 1'b1);
      chk("R2 borrow", {31'b0, co, s}, {31'b0, 1'b0, 32'hFFFF_FFFC});
      drive(32'd5, 32'd9, 1'b1, 1'b1);
      chk("R2 cin ignored while subtracting", {31'b0, co, s}, {31'b0, 1'b0, 32'hFFFF_FFFC});
      drive(32'h8000_0000, 32'd1, 1'b0, 1'b1);
      chk("R2 top bit difference", {31'b0, co, s}, {31'b0, 1'b1, 32'h7FFF_FFFF});
      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] xa, xb;
         logic xc;
         xa = $urandom; xb = $urandom; xc = 1'($urandom);
         drive(xa, xb, xc, 1'b1);
         chk("R2 random difference", {32'b0, s}, {32'b0, xa - xb});
         chk("R2 random no-borrow", {63'b0, co}, {63'b0, xa >= xb});
         chk("R3 carries when subtracting", {32'b0, s ^ xa ^ ~xb},
             {32'b0, ref_carries(xa, ~xb, 1'b1)});
      end
   endtask

   task automatic t_narrow_exhaustive();
      for (int x = 0; x < (1 << WL); x++) begin
         for (int y = 0; y < (1 << WL); y++) begin
            for (int c = 0; c < 2; c++) begin
               logic [WL:0] e;
               la = WL'(x); lb = WL'(y); lci = c[0]; lsb = 1'($urandom);
               e = {1'b0, la} + {1'b0, lb} + {{WL{1'b0}}, lci};
               #1;
               chk("R7 sub has no effect when disabled", {55'b0, lco, ls}, {55'b0, e});
               chk("R8 linear tree equals log tree", {55'b0, lco, ls}, {55'b0, lco_ref, ls_ref});
            end
         end
      end
   endtask

   initial begin
      a = '0; b = '0; ci = 1'b0; sb = 1'b0;
      la = '0; lb = '0; lci = 1'b0; lsb = 1'b0;
      t_zero();
      t_all_ones();
      t_alternating();
      t_random_add();
      t_subtract();
      t_narrow_exhaustive();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule